// File: doc/BRIEF.md
# Interleaved Flash Erase Range Walker

This block turns one erase request (a byte address and a byte length over a bank of flash chips) into a series of per-block commands for a downstream erase sequencer. Each chip slot holds a power-of-two number of devices side by side, so one slot spans `2^CHIP_SHIFT << ILV_LOG2` bytes. The walker first checks the request. It rejects a start or a length that is not a whole number of erase blocks, and it rejects a range that runs past the array. It then splits the address into a chip index and an offset inside that chip.

It issues one command per erase block and waits for the sequencer's response before it issues the next. After each good response it advances the offset. When the offset reaches the end of the chip, it moves to the start of the next chip. The walk ends with a completion pulse when the length is used up or when the chip index reaches the chip count. It ends with an abort pulse when the sequencer reports an error, and with a reject pulse when the request fails its checks.

Top module: `erase_range_walker`

## Requirements
- R1: A request whose address has any bit below BLOCK_SHIFT set ends with a reject pulse and issues no command.
- R2: A request whose length has any bit below BLOCK_SHIFT set ends with a reject pulse and issues no command.
- R3: A request with address + length greater than NUM_CHIPS << (DEV_SHIFT + ILV_LOG2) ends with a reject pulse and issues no command.
- R4: The first command carries chip = address >> (CHIP_SHIFT + ILV_LOG2) and offset = the address bits below CHIP_SHIFT + ILV_LOG2.
- R5: Each later command carries the previous offset plus 2^BLOCK_SHIFT on the same chip. When that sum reaches the chip span, the command carries offset 0 on the next chip.
- R6: The walk ends with a completion pulse, leaving any length unissued, as soon as the chip index reaches NUM_CHIPS. A zero length, or a start chip at or above NUM_CHIPS, completes with no command.
- R7: A response with the error flag set ends the walk with an abort pulse in the next cycle, and no further command is issued.
- R8: A valid request within the array completes after exactly length >> BLOCK_SHIFT good responses.
- R9: The cycle after a request is accepted issues no command and gives no outcome. Each command is held, with chip and offset unchanged, until it is accepted. A new request is accepted only when the walker is idle.
- R10: The done, reject and abort pulses last one cycle each, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_addr | input | ADDR_W | Byte start address of the range |
| req_len | input | ADDR_W | Byte length of the range |
| cmd_valid | output | 1 | Per-block erase command offered |
| cmd_ready | input | 1 | Sequencer takes the command |
| cmd_chip | output | CHIP_W | Chip index of the block |
| cmd_offset | output | CHIP_SHIFT+ILV_LOG2 | Byte offset of the block inside the chip |
| rsp_valid | input | 1 | Sequencer finished the outstanding block |
| rsp_err | input | 1 | Sequencer reports the block failed |
| done_pulse | output | 1 | Walk completed |
| reject_pulse | output | 1 | Request failed alignment or bounds checks |
| abort_pulse | output | 1 | Walk stopped by a sequencer error |

## Verification
The properties assume that the sequencer raises rsp_valid only once for each accepted command, and only after that command has been accepted. The checker keeps its own outstanding flag, so the abort property applies only to a response that belongs to a live command. The bench's sequencer model follows this rule. It stalls cmd_ready and delays each response by a varying number of cycles, and it offers a request only while req_ready is high. It also sweeps every aligned address and length across a small three-chip array, including ranges that reach past the last chip but stay inside the declared device size.

// File: rtl/erw_pkg.sv
package erw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } erw_state_e;
endpackage

// File: rtl/erw_req_check.sv
module erw_req_check #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_SHIFT = 17,
    parameter int SPAN_SHIFT  = 23,
    parameter int DEV_SHIFT   = 22,
    parameter int ILV_LOG2    = 1,
    parameter int NUM_CHIPS   = 4,
    parameter int CHIP_W      = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [ADDR_W-1:0]     len,
    output logic                  bad,
    output logic                  empty,
    output logic [CHIP_W-1:0]     chip,
    output logic [SPAN_SHIFT-1:0] ofs
);
    localparam logic [ADDR_W:0] TOTAL_BYTES =
        (ADDR_W+1)'(NUM_CHIPS) << (DEV_SHIFT + ILV_LOG2);

    logic [ADDR_W:0]   end_addr;
    logic [ADDR_W-1:0] chip_full;
    logic              misalign;

    always_comb begin
        misalign  = (|addr[BLOCK_SHIFT-1:0]) || (|len[BLOCK_SHIFT-1:0]);
        end_addr  = {1'b0, addr} + {1'b0, len};
        bad       = misalign || (end_addr > TOTAL_BYTES);
        chip_full = addr >> SPAN_SHIFT;
        empty     = (len == '0) || (chip_full >= ADDR_W'(NUM_CHIPS));
        chip      = chip_full[CHIP_W-1:0];
        ofs       = addr[SPAN_SHIFT-1:0];
    end
endmodule

// File: rtl/erw_step.sv
module erw_step #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_SHIFT = 17,
    parameter int SPAN_SHIFT  = 23,
    parameter int NUM_CHIPS   = 4,
    parameter int CHIP_W      = 2
) (
    input  logic [CHIP_W-1:0]     chip,
    input  logic [SPAN_SHIFT-1:0] ofs,
    input  logic [ADDR_W-1:0]     len,
    output logic [CHIP_W-1:0]     nxt_chip,
    output logic [SPAN_SHIFT-1:0] nxt_ofs,
    output logic [ADDR_W-1:0]     nxt_len,
    output logic                  finished
);
    localparam logic [SPAN_SHIFT:0] OFS_STEP = (SPAN_SHIFT+1)'(1) << BLOCK_SHIFT;
    localparam logic [ADDR_W-1:0]   LEN_STEP = ADDR_W'(1) << BLOCK_SHIFT;

    logic [SPAN_SHIFT:0] ofs_sum;
    logic [CHIP_W:0]     chip_inc;
    logic                wrap;

    always_comb begin
        ofs_sum  = {1'b0, ofs} + OFS_STEP;
        wrap     = ofs_sum[SPAN_SHIFT];
        chip_inc = {1'b0, chip} + (CHIP_W+1)'(1);
        nxt_len  = len - LEN_STEP;
        nxt_ofs  = wrap ? '0 : ofs_sum[SPAN_SHIFT-1:0];
        nxt_chip = wrap ? chip_inc[CHIP_W-1:0] : chip;
        finished = (nxt_len == '0) ||
                   (wrap && (chip_inc == (CHIP_W+1)'(NUM_CHIPS)));
    end
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
    import erw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_SHIFT = 17,
    parameter int CHIP_SHIFT  = 22,
    parameter int DEV_SHIFT   = 22,
    parameter int ILV_LOG2    = 1,
    parameter int NUM_CHIPS   = 4,
    localparam int SPAN_SHIFT = CHIP_SHIFT + ILV_LOG2,
    localparam int CHIP_W     = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [ADDR_W-1:0]     req_len,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [CHIP_W-1:0]     cmd_chip,
    output logic [SPAN_SHIFT-1:0] cmd_offset,
    input  logic                  rsp_valid,
    input  logic                  rsp_err,
    output logic                  done_pulse,
    output logic                  reject_pulse,
    output logic                  abort_pulse
);
    typedef struct packed {
        erw_state_e            st;
        logic [ADDR_W-1:0]     addr;
        logic [ADDR_W-1:0]     len;
        logic [CHIP_W-1:0]     chip;
        logic [SPAN_SHIFT-1:0] ofs;
        logic                  done;
        logic                  reject;
        logic                  abort;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic                  chk_bad, chk_empty;
    logic [CHIP_W-1:0]     chk_chip;
    logic [SPAN_SHIFT-1:0] chk_ofs;
    logic [CHIP_W-1:0]     stp_chip;
    logic [SPAN_SHIFT-1:0] stp_ofs;
    logic [ADDR_W-1:0]     stp_len;
    logic                  stp_fin;

    erw_req_check #(
        .ADDR_W(ADDR_W), .BLOCK_SHIFT(BLOCK_SHIFT), .SPAN_SHIFT(SPAN_SHIFT),
        .DEV_SHIFT(DEV_SHIFT), .ILV_LOG2(ILV_LOG2), .NUM_CHIPS(NUM_CHIPS),
        .CHIP_W(CHIP_W)
    ) u_check (
        .addr(r_q.addr), .len(r_q.len),
        .bad(chk_bad), .empty(chk_empty), .chip(chk_chip), .ofs(chk_ofs)
    );

    erw_step #(
        .ADDR_W(ADDR_W), .BLOCK_SHIFT(BLOCK_SHIFT), .SPAN_SHIFT(SPAN_SHIFT),
        .NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W)
    ) u_step (
        .chip(r_q.chip), .ofs(r_q.ofs), .len(r_q.len),
        .nxt_chip(stp_chip), .nxt_ofs(stp_ofs), .nxt_len(stp_len),
        .finished(stp_fin)
    );

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.reject = 1'b0;
        r_d.abort  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.len  = req_len;
                    r_d.st   = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (chk_bad) begin
                    r_d.reject = 1'b1;
                    r_d.st     = ST_IDLE;
                end else if (chk_empty) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.chip = chk_chip;
                    r_d.ofs  = chk_ofs;
                    r_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        r_d.abort = 1'b1;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.chip = stp_chip;
                        r_d.ofs  = stp_ofs;
                        r_d.len  = stp_len;
                        if (stp_fin) begin
                            r_d.done = 1'b1;
                            r_d.st   = ST_IDLE;
                        end else begin
                            r_d.st = ST_ISSUE;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_ready    = (r_q.st == ST_IDLE);
    assign cmd_valid    = (r_q.st == ST_ISSUE);
    assign cmd_chip     = r_q.chip;
    assign cmd_offset   = r_q.ofs;
    assign done_pulse   = r_q.done;
    assign reject_pulse = r_q.reject;
    assign abort_pulse  = r_q.abort;
endmodule

// File: rtl/erw_walker_chk.sv
module erw_walker_chk #(
    parameter int NUM_CHIPS   = 4,
    parameter int CHIP_W      = 2,
    parameter int SPAN_SHIFT  = 23,
    parameter int BLOCK_SHIFT = 17
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  cmd_valid,
    input logic                  cmd_ready,
    input logic [CHIP_W-1:0]     cmd_chip,
    input logic [SPAN_SHIFT-1:0] cmd_offset,
    input logic                  rsp_valid,
    input logic                  rsp_err,
    input logic                  done_pulse,
    input logic                  reject_pulse,
    input logic                  abort_pulse
);
    logic outst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      outst_q <= 1'b0;
        else if (cmd_valid && cmd_ready) outst_q <= 1'b1;
        else if (rsp_valid)              outst_q <= 1'b0;
    end

    p_check_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            !cmd_valid && !done_pulse && !reject_pulse && !abort_pulse);

    p_chip_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ({1'b0, cmd_chip} < (CHIP_W+1)'(NUM_CHIPS)));

    p_offset_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_offset[BLOCK_SHIFT-1:0] == '0));

    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            cmd_valid && $stable(cmd_chip) && $stable(cmd_offset));

    p_busy_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

    p_single_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !cmd_valid);

    p_err_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err && outst_q) |=> abort_pulse && !cmd_valid);

    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_pulse, reject_pulse, abort_pulse}));

    p_pulse_short_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse || reject_pulse || abort_pulse) |=>
            !(done_pulse || reject_pulse || abort_pulse));
endmodule

bind erase_range_walker erw_walker_chk #(
    .NUM_CHIPS(NUM_CHIPS), .CHIP_W(CHIP_W),
    .SPAN_SHIFT(SPAN_SHIFT), .BLOCK_SHIFT(BLOCK_SHIFT)
) u_walk_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_chip(cmd_chip),
    .cmd_offset(cmd_offset), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .done_pulse(done_pulse), .reject_pulse(reject_pulse),
    .abort_pulse(abort_pulse)
);

// File: tb/test_erase_range_walker.sv
`timescale 1ns/1ps
module test_erase_range_walker;
    localparam int AW   = 8;
    localparam int BSH  = 2;
    localparam int CSH  = 3;
    localparam int DSH  = 4;
    localparam int ILV  = 1;
    localparam int NCH  = 3;
    localparam int SPAN = 1 << (CSH + ILV);
    localparam int BLK  = 1 << BSH;
    localparam int TOT  = NCH << (DSH + ILV);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] req_len = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_chip;
    logic [3:0]    cmd_offset;
    logic          rsp_valid = 1'b0;
    logic          rsp_err = 1'b0;
    logic          done_pulse, reject_pulse, abort_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    erase_range_walker #(
        .ADDR_W(AW), .BLOCK_SHIFT(BSH), .CHIP_SHIFT(CSH),
        .DEV_SHIFT(DSH), .ILV_LOG2(ILV), .NUM_CHIPS(NCH)
    ) i_erase_range_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_chip(cmd_chip), .cmd_offset(cmd_offset),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .done_pulse(done_pulse),
        .reject_pulse(reject_pulse), .abort_pulse(abort_pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // outcome kinds: 0 done, 1 reject, 2 abort
    task automatic run_req(input int a, input int l, input int err_at);
        int    exp_chip[$];
        int    exp_ofs[$];
        int    exp_kind;
        int    exp_n;
        string tag;
        int    chip, ofs, rem;
        int    ncmd, got, stall, wait_cnt;
        bit    awaiting, err_sent;

        exp_kind = 0;
        if ((a % BLK) != 0)       begin exp_kind = 1; tag = "R1"; end
        else if ((l % BLK) != 0)  begin exp_kind = 1; tag = "R2"; end
        else if (a + l > TOT)     begin exp_kind = 1; tag = "R3"; end
        else begin
            chip = a / SPAN; ofs = a % SPAN; rem = l;
            while (rem > 0 && chip < NCH) begin
                exp_chip.push_back(chip);
                exp_ofs.push_back(ofs);
                ofs += BLK; rem -= BLK;
                if (ofs >= SPAN) begin ofs = 0; chip++; end
            end
            tag = (exp_chip.size() == l / BLK) ? "R8" : "R6";
        end
        exp_n = (exp_kind == 1) ? 0 : exp_chip.size();
        if (err_at >= 0 && err_at < exp_n) begin
            exp_kind = 2; exp_n = err_at + 1; tag = "R7";
        end

        @(negedge clk);
        check(req_ready == 1'b1, "R9 idle before request", req_ready, 1);
        req_addr = AW'(a); req_len = AW'(l); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ncmd = 0; got = -1; stall = (a / BLK) % 2; wait_cnt = 0;
        awaiting = 1'b0; err_sent = 1'b0;
        for (int cyc = 0; cyc < 400 && got < 0; cyc++) begin
            cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0;
            if (err_sent) begin
                check(abort_pulse == 1'b1, "R7 abort in cycle after error", abort_pulse, 1);
                err_sent = 1'b0;
            end
            if (done_pulse || reject_pulse || abort_pulse) begin
                got = done_pulse ? 0 : (reject_pulse ? 1 : 2);
            end else if (awaiting) begin
                if (wait_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_err   = (ncmd - 1 == err_at);
                    err_sent  = rsp_err;
                    awaiting  = 1'b0;
                end else wait_cnt--;
            end else if (cmd_valid) begin
                check(req_ready == 1'b0, "R9 busy while commanding", req_ready, 0);
                if (stall == 0) begin
                    cmd_ready = 1'b1;
                    if (ncmd < exp_chip.size()) begin
                        check(int'(cmd_chip) == exp_chip[ncmd],
                              (ncmd == 0) ? "R4 chip" : "R5 chip", cmd_chip, exp_chip[ncmd]);
                        check(int'(cmd_offset) == exp_ofs[ncmd],
                              (ncmd == 0) ? "R4 offset" : "R5 offset", cmd_offset, exp_ofs[ncmd]);
                    end
                    ncmd++;
                    awaiting = 1'b1;
                    wait_cnt = ncmd % 3;
                    stall    = ncmd % 2;
                end else stall--;
            end
            if (got < 0) @(negedge clk);
        end
        cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0;
        check(got == exp_kind, {tag, " outcome"}, got, exp_kind);
        check(ncmd == exp_n, {tag, " command count"}, ncmd, exp_n);
        @(negedge clk);
        check({done_pulse, reject_pulse, abort_pulse} == 3'b000,
              "R10 pulse lasts one cycle", {done_pulse, reject_pulse, abort_pulse}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
        check(cmd_valid == 1'b0, "R9 reset no command", cmd_valid, 0);
        check({done_pulse, reject_pulse, abort_pulse} == 3'b000,
              "R10 reset pulses", {done_pulse, reject_pulse, abort_pulse}, 0);
        rst_n = 1'b1;
        // aligned sweep: R3, R4, R5, R6, R8
        for (int a = 0; a <= TOT + BLK; a += BLK)
            for (int l = 0; l <= TOT + BLK; l += BLK)
                run_req(a, l, -1);
        // misaligned address: R1
        for (int a = 1; a < TOT; a++)
            if ((a % BLK) != 0) run_req(a, 2 * BLK, -1);
        // misaligned length: R2
        for (int l = 1; l < TOT; l++)
            if ((l % BLK) != 0) run_req(0, l, -1);
        // sequencer errors: R7
        run_req(0, 12 * BLK, 0);
        run_req(0, 12 * BLK, 1);
        run_req(0, 12 * BLK, 5);
        run_req(0, 12 * BLK, 11);
        run_req(2 * BLK, 8 * BLK, 3);
        run_req(SPAN - BLK, 4 * BLK, 1);
        run_req(0, 4 * BLK, -1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule